// File: doc/BRIEF.md
# Clock-Stop Serial Peripheral Master with Divided Bit Clock

This block is a serial peripheral master with a stopped clock. It sends one word on a data output and, in the same transfer, collects one word from a data input. A one-cycle start request captures the transmit word, the clock divisor and the divider source. The block then pulls an active-low select, waits a lead time, and toggles a bit clock that idles low. Data leaves on rising clock edges and is sampled on falling edges. After a short tail the block releases the select and presents the collected word with a one-cycle done pulse.

The bit clock comes from a tick stream. One choice of source gives one tick every six system cycles. The other takes an external single-cycle enable. A bit-clock period lasts `divisor + 1` ticks. With an even divisor the high phase is one tick longer than the low phase. With an odd divisor the two phases are equal. The data output has its own enable, which a pad driver uses to float the line outside a transfer.

Top module: `spim_master`

## Requirements
- R1: After reset and between transfers, `ssN` is 1, `sclk` is 0, `sdoOe` is 0, `busy` is 0 and `rxDone` is 0.
- R2: A `startReq` pulse while idle drives `ssN` to 0 and `sdoOe` to 1 from the next cycle. Bit `WORD_W-1` of `txWord` appears on `sdo`. The first rising `sclk` edge follows `divisor+1` ticks later. With an internal source this is 6·(divisor+1) cycles.
- R3: For an even divisor, `sclk` stays high for divisor/2+1 ticks and low for divisor/2 ticks between bits.
- R4: For an odd divisor, the high and the low phase of `sclk` each last (divisor+1)/2 ticks.
- R5: For a divisor of 0, each bit period lasts one tick. `sclk` is high for all of it but one system cycle and low for that one cycle. The lead time and the tail each grow by that one cycle. The external enable must then come no more often than every second cycle.
- R6: With `srcSel`=1 a tick occurs every 6 system cycles, counted from the start. With `srcSel`=0 a tick is any cycle with `extTick`=1.
- R7: `sdo` sends `txWord` most significant bit first. It changes only at the second and later rising edges of `sclk`, and it gives exactly `WORD_W` rising edges per transfer.
- R8: `sdi` is sampled at each falling `sclk` edge. The first sample becomes bit `WORD_W-1` of `rxWord`.
- R9: After the last falling edge, `ssN` stays 0 for one low phase (one cycle when the divisor is 0) and then returns to 1. `sdoOe` falls in the same cycle, and `sdoOe` is 1 exactly while `ssN` is 0.
- R10: `rxDone` is a one-cycle pulse in the cycle `ssN` returns to 1. `rxWord` then holds the collected word until the next transfer ends.
- R11: A `startReq` while `busy` is 1 is ignored. It neither restarts nor queues a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, accepted when idle |
| txWord | input | WORD_W | Word to transmit |
| divisor | input | DIV_W | Bit clock divisor, captured at start |
| srcSel | input | 1 | Tick source: 1 = system clock divided by 6, 0 = extTick |
| extTick | input | 1 | External tick enable |
| sdi | input | 1 | Serial data from the slave |
| sclk | output | 1 | Bit clock, idles low |
| ssN | output | 1 | Active-low slave select |
| sdo | output | 1 | Serial data to the slave |
| sdoOe | output | 1 | Output enable for the sdo pad driver |
| rxWord | output | WORD_W | Last collected word |
| rxDone | output | 1 | One-cycle pulse when rxWord is updated |
| busy | output | 1 | Transfer in progress |

## Verification
The bench times each clock phase in system cycles and compares it with the tick arithmetic. It covers odd and even divisors, a divisor of zero and both tick sources. A design that split an even divisor evenly, or that let the zero-divisor low phase last zero cycles, would fail there. A lead time counted in bit periods instead of ticks would fail the same way. A slave model returns a different word each time and records the MSB-first stream on `sdo`. A design that shifted on the first rising edge, sampled on the wrong edge or reversed the bit order would corrupt one of the two words. A start request given mid-transfer must leave the current word intact and must not cause a second select pulse.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int SYS_DIV = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } spimState_t;

  // strobes from control to datapath, all valid for a single cycle
  typedef struct packed {
    logic load;      // capture txWord, clear receive shifter
    logic shiftTx;   // present next transmit bit
    logic sampleRx;  // shift sdi into receive shifter
    logic finish;    // publish received word
  } spimStrobe_t;

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  srcSel,
  input  logic                  extTick,
  input  logic [DIV_W-1:0]      divisor,
  output spim_pkg::spimStrobe_t stb,
  output logic                  sclk,
  output logic                  ssN,
  output logic                  sdoOe,
  output logic                  busy
);
  import spim_pkg::*;

  localparam int CNT_W = DIV_W + 1;
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam int SD_W  = $clog2(SYS_DIV);

  spimState_t       state, stateN;
  logic [DIV_W-1:0] gdvQ;
  logic             srcQ;
  logic [SD_W-1:0]  divCnt;
  logic [CNT_W-1:0] phCnt, phCntN, phNext;
  logic [BIT_W-1:0] bitCnt, bitCntN;
  logic             sclkN, ssNN, oeN;
  logic             tick, lowZero;
  logic [CNT_W-1:0] periodLen, highLen, lowLen;

  // tick source: fixed divide-by-six restarted per transfer, or external enable
  assign tick = srcQ ? (divCnt == SD_W'(SYS_DIV - 1)) : extTick;

  // phase lengths in ticks
  assign periodLen = CNT_W'(gdvQ) + CNT_W'(1);
  assign highLen   = gdvQ[0] ? (periodLen >> 1) : (CNT_W'(gdvQ >> 1) + CNT_W'(1));
  assign lowLen    = periodLen - highLen;
  assign lowZero   = (lowLen == '0);
  assign phNext    = phCnt + CNT_W'(1);

  always_comb begin
    stb     = '0;
    stateN  = state;
    phCntN  = tick ? phNext : phCnt;
    bitCntN = bitCnt;
    sclkN   = sclk;
    ssNN    = ssN;
    oeN     = sdoOe;
    unique case (state)
      ST_IDLE: begin
        phCntN = '0;
        if (startReq) begin
          stb.load = 1'b1;
          stateN   = ST_LEAD;
          bitCntN  = '0;
          ssNN     = 1'b0;
          oeN      = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick && phNext == periodLen) begin
          phCntN = '0;
          if (lowZero) begin
            stateN = ST_LOW;
          end else begin
            stateN = ST_HIGH;
            sclkN  = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (tick && phNext == highLen) begin
          phCntN       = '0;
          sclkN        = 1'b0;
          stb.sampleRx = 1'b1;
          bitCntN      = bitCnt + BIT_W'(1);
          stateN       = (bitCnt == BIT_W'(WORD_W - 1)) ? ST_TAIL : ST_LOW;
        end
      end
      ST_LOW: begin
        if (lowZero || (tick && phNext == lowLen)) begin
          phCntN      = '0;
          sclkN       = 1'b1;
          stateN      = ST_HIGH;
          stb.shiftTx = (bitCnt != '0);
        end
      end
      ST_TAIL: begin
        if (lowZero || (tick && phNext == lowLen)) begin
          phCntN     = '0;
          ssNN       = 1'b1;
          oeN        = 1'b0;
          stb.finish = 1'b1;
          stateN     = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gdvQ   <= '0;
      srcQ   <= 1'b1;
      divCnt <= '0;
      phCnt  <= '0;
      bitCnt <= '0;
      sclk   <= 1'b0;
      ssN    <= 1'b1;
      sdoOe  <= 1'b0;
    end else begin
      state  <= stateN;
      phCnt  <= phCntN;
      bitCnt <= bitCntN;
      sclk   <= sclkN;
      ssN    <= ssNN;
      sdoOe  <= oeN;
      if (state == ST_IDLE && startReq) begin
        gdvQ <= divisor;
        srcQ <= srcSel;
      end
      if (state == ST_IDLE || divCnt == SD_W'(SYS_DIV - 1)) divCnt <= '0;
      else                                                 divCnt <= divCnt + SD_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spim_dpath.sv
module spim_dpath #(
  parameter int WORD_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spim_pkg::spimStrobe_t stb,
  input  logic [WORD_W-1:0]     txWord,
  input  logic                  sdi,
  output logic                  sdo,
  output logic [WORD_W-1:0]     rxWord,
  output logic                  rxDone
);

  logic [WORD_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
      rxDone  <= 1'b0;
    end else begin
      if (stb.load)         txShift <= txWord;
      else if (stb.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};

      if (stb.load)          rxShift <= '0;
      else if (stb.sampleRx) rxShift <= {rxShift[WORD_W-2:0], sdi};

      if (stb.finish) rxWord <= rxShift;
      rxDone <= stb.finish;
    end
  end

  assign sdo = txShift[WORD_W-1];

endmodule

// File: rtl/spim_master.sv
module spim_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WORD_W-1:0] txWord,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              srcSel,
  input  logic              extTick,
  input  logic              sdi,
  output logic              sclk,
  output logic              ssN,
  output logic              sdo,
  output logic              sdoOe,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxDone,
  output logic              busy
);

  spim_pkg::spimStrobe_t stb;

  spim_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .srcSel(srcSel),
    .extTick(extTick), .divisor(divisor), .stb(stb), .sclk(sclk),
    .ssN(ssN), .sdoOe(sdoOe), .busy(busy)
  );

  spim_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(txWord), .sdi(sdi),
    .sdo(sdo), .rxWord(rxWord), .rxDone(rxDone)
  );

endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic busy,
  input logic ssN,
  input logic sclk,
  input logic sdo,
  input logic sdoOe,
  input logic rxDone
);

  // R1: with the select released the clock rests low
  p_clk_rests_r1: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sclk);

  // R2: a select assertion is always caused by an accepted start
  p_sel_from_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> ($past(startReq) && !$past(busy)));

  // R7: inside a transfer the data output moves only together with a rising clock
  p_sdo_on_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ssN && $past(!ssN) && !$rose(sclk)) |-> $stable(sdo));

  // R9: the pad driver is enabled exactly while the select is asserted
  p_oe_follows_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe != ssN);

  // R10: done is a single-cycle pulse aligned with the select release
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);
  p_done_at_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> $rose(ssN));

endmodule

bind spim_master spim_master_chk u_chk (.*);

// File: tb/spim_master_tb.sv
module spim_master_tb;

  localparam int W     = 8;
  localparam int DW    = 8;
  localparam int EXT_P = 3;

  typedef struct {
    logic [W-1:0] mosi;
    logic [W-1:0] miso;
    int           gdv;
    bit           src;
  } xfer_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [W-1:0]  txWord = '0;
  logic [DW-1:0] divisor = '0;
  logic          srcSel = 1'b1;
  logic          extTick = 1'b0;
  logic          sdi = 1'b0;
  logic          sclk, ssN, sdo, sdoOe, rxDone, busy;
  logic [W-1:0]  rxWord;

  int checks = 0;
  int errors = 0;
  xfer_t expQ[$];
  logic [W-1:0] lastMiso = '0;

  always #2 clk = ~clk;

  spim_master #(.WORD_W(W), .DIV_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txWord(txWord),
    .divisor(divisor), .srcSel(srcSel), .extTick(extTick), .sdi(sdi),
    .sclk(sclk), .ssN(ssN), .sdo(sdo), .sdoOe(sdoOe), .rxWord(rxWord),
    .rxDone(rxDone), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // external tick: one cycle in EXT_P
  int extCnt = 0;
  always @(negedge clk) begin
    extCnt  = (extCnt == EXT_P - 1) ? 0 : extCnt + 1;
    extTick = (extCnt == EXT_P - 1);
  end

  // monitor and slave model
  xfer_t cur;
  int cyc = 0, ssFallCyc = 0, lastRise = 0, lastFall = 0, rises = 0, sidx = 0;
  int tp = 6, tT = 1, tH = 1, tL = 0, lz = 0, hiExp = 0, loExp = 0;
  logic prevSs = 1'b1, prevSclk = 1'b0;
  logic [W-1:0] mosiCap = '0;
  string hiTag;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevSs && !ssN) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R11", 1, 0);
        end else begin
          cur = expQ.pop_front();
          tp = cur.src ? 6 : EXT_P;
          tT = cur.gdv + 1;
          tH = (cur.gdv % 2 == 1) ? (cur.gdv + 1) / 2 : cur.gdv / 2 + 1;
          tL = tT - tH;
          lz = (tL == 0);
          hiExp = lz ? tp - 1 : tp * tH;
          loExp = lz ? 1 : tp * tL;
          hiTag = (cur.gdv == 0) ? "R5" : ((cur.gdv % 2 == 1) ? "R4" : "R3");
        end
        ssFallCyc = cyc; rises = 0; mosiCap = '0; sidx = W - 1;
        sdi = cur.miso[W-1];
        chk(sdoOe == 1'b1, "R2", sdoOe, 1);
        chk(sdo == cur.mosi[W-1], "R7", sdo, cur.mosi[W-1]);
      end
      if (!prevSclk && sclk) begin
        rises++;
        if (rises == 1) begin
          if (cur.src)
            chk(cyc - ssFallCyc == tp * tT + lz, "R2", cyc - ssFallCyc, tp * tT + lz);
          else
            chk((cyc - ssFallCyc <= tp * tT + lz) && (cyc - ssFallCyc >= tp * (tT - 1) + 1 + lz),
                "R6", cyc - ssFallCyc, tp * tT + lz);
        end else begin
          chk(cyc - lastFall == loExp, hiTag, cyc - lastFall, loExp);
          if (sidx > 0) sidx--;
          sdi = cur.miso[sidx];
        end
        lastRise = cyc;
      end
      if (prevSclk && !sclk) begin
        chk(cyc - lastRise == hiExp, hiTag, cyc - lastRise, hiExp);
        mosiCap = {mosiCap[W-2:0], sdo};
        lastFall = cyc;
      end
      if (!prevSs && ssN) begin
        chk(cyc - lastFall == loExp, "R9", cyc - lastFall, loExp);
        chk(sdoOe == 1'b0, "R9", sdoOe, 0);
        chk(rises == W, "R7", rises, W);
        chk(mosiCap == cur.mosi, "R7", mosiCap, cur.mosi);
        chk(rxDone == 1'b1, "R10", rxDone, 1);
        chk(rxWord == cur.miso, "R8", rxWord, cur.miso);
        lastMiso = cur.miso;
      end else if (rxDone) begin
        chk(1'b0, "R10", rxDone, 0);
      end
    end
    prevSs   = ssN;
    prevSclk = sclk;
  end

  task automatic startXfer(input logic [W-1:0] tx, input logic [W-1:0] rx, input int gdv, input bit src);
    xfer_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.mosi = tx; e.miso = rx; e.gdv = gdv; e.src = src;
    expQ.push_back(e);
    txWord = tx; divisor = DW'(gdv); srcSel = src; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ssN == 1'b1, "R1", ssN, 1);
    chk(sclk == 1'b0, "R1", sclk, 0);
    chk(sdoOe == 1'b0, "R1", sdoOe, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(rxDone == 1'b0, "R1", rxDone, 0);

    startXfer(8'hA5, 8'h3C, 3, 1'b1); waitIdle();   // R4 odd, internal
    startXfer(8'h81, 8'hF0, 4, 1'b1); waitIdle();   // R3 even, internal
    startXfer(8'h5E, 8'h96, 0, 1'b1); waitIdle();   // R5 zero, internal
    startXfer(8'hC3, 8'h01, 0, 1'b0); waitIdle();   // R5/R6 zero, external
    startXfer(8'h27, 8'hDB, 5, 1'b0); waitIdle();   // R4/R6 external
    startXfer(8'hFE, 8'h7F, 2, 1'b0); waitIdle();   // R3/R6 external

    // R11: start during a transfer is ignored
    startXfer(8'h69, 8'hB4, 1, 1'b1);
    repeat (20) @(negedge clk);
    txWord = 8'h00; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    repeat (50) @(negedge clk);
    chk(ssN == 1'b1 && busy == 1'b0, "R11", {ssN, busy}, 2);
    chk(expQ.size() == 0, "R11", expQ.size(), 0);
    // R10: word holds after the pulse
    chk(rxWord == lastMiso, "R10", rxWord, lastMiso);
    chk(rxDone == 1'b0 && sclk == 1'b0 && sdoOe == 1'b0, "R1", {rxDone, sclk, sdoOe}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule